// File: doc/BRIEF.md
# Redirection Table Register Window

This block is the bus-facing register front end of an interrupt redirection controller. Software sees two 16-byte-aligned locations only. One is an 8-bit select register. The other is a 32-bit data window, whose meaning depends on the current select value. Through the window, software reaches a version word, an identification word, an arbitration word (which mirrors the identification), and one 64-bit redirection entry per input pin. Each entry is reached as two 32-bit halves.

The entries are held in local flops, and the pin count is a parameter. Two bits in each entry belong to the servicing logic next to this block: remote-IRR and delivery-status. Software writes never change them. The block emits two single-cycle events after a table write. A mask-change event carries the pin index and the new mask value. A re-evaluation event tells the servicing logic to look at a pin again. The block does not service pins and does not deliver interrupts. The whole table is exported so a neighbour can decode it.

Requests use a valid/ready handshake, and each request is accepted in one cycle. Read data returns from a register one cycle after the read is accepted.

Top module: `irq_regwin`

## Requirements
- R1: After reset, every entry reads 0x0001_0000 on its low half (only the mask, bit 16, set) and 0 on its high half. The select register reads 0, and the identification word reads 0.
- R2: Only offset 0x00 (select) and offset 0x10 (window) respond. A read at any other aligned offset, or at any address whose low four bits are not zero, returns 0. A write there changes nothing.
- R3: A write to offset 0x00 stores the low 8 bits of the data. A read of offset 0x00 returns that value zero-extended, and later window accesses use it.
- R4: Select 0x01 is the version word: PINS-1 in bits 23:16, the VERSION parameter in bits 7:0, and zeros elsewhere. Writes to it have no effect.
- R5: Select 0x00 is the identification word: a write stores data bits 27:24, and a read returns them in bits 27:24 with zeros elsewhere. Select 0x02 reads the same value, and writes through select 0x02 are ignored.
- R6: Select values from 0x10 upward address the table. The pin is (select-0x10)>>1, and select bit 0 = 1 picks bits 63:32 of the entry. All bits other than 12 and 14 read back as written.
- R7: A table access whose pin is PINS or more, or a select of 0x03 to 0x0F, reads 0xFFFF_FFFF. Writes there change no entry and raise no event.
- R8: A low-half write leaves remote-IRR (bit 14) and delivery-status (bit 12) as they were, whatever the data holds. The exception is the rule in R9.
- R9: When an entry's trigger-mode bit (bit 15, 1 = level, 0 = edge) is 0 after a write to either half, its remote-IRR bit becomes 0.
- R10: req_ready is high in every cycle out of reset. rsp_valid is high for exactly the one cycle after each accepted read, and for no other cycle.
- R11: A low-half write that changes an entry's mask bit raises mask_chg_vld in the next cycle, with mask_chg_pin = the pin and mask_chg_val = the new mask value. Any other write leaves mask_chg_vld low.
- R12: A write to either half of an entry that is level-triggered after the write, while pin_pend for that pin is high, raises reeval_vld in the next cycle with reeval_pin = the pin. No other write raises it.
- R13: A pulse on hw_rirr_set sets remote-IRR and a pulse on hw_rirr_clr clears it. The delivery-status bit takes the value of hw_dlv_stat one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset inside the block |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| pin_pend | input | PINS | Pending request per pin, from the pin logic |
| hw_rirr_set | input | PINS | Set remote-IRR per pin |
| hw_rirr_clr | input | PINS | Clear remote-IRR per pin |
| hw_dlv_stat | input | PINS | Delivery-status value per pin |
| tbl_q | output | PINS x 64 | All redirection entries |
| mask_chg_vld | output | 1 | Mask-change event |
| mask_chg_pin | output | IDX_W | Pin whose mask changed |
| mask_chg_val | output | 1 | New mask value |
| reeval_vld | output | 1 | Re-evaluation event |
| reeval_pin | output | IDX_W | Pin to re-evaluate |

## Verification
The select value is swept over every table pin, the three fixed words, the unused gap below 0x10 and the indexes past the pin count. Together these separate the version, identification and table decode from the all-ones default and the zero returned for dead offsets. Entry writes are tried with data that toggles the two protected bits, with the servicing inputs held in both states, and with level and edge trigger modes. These cases separate a preserved status bit from one that was copied from the data, and show the edge-mode clear. The event outputs are checked after writes that change the mask, writes that leave it unchanged, high-half writes, and writes with the pending input both high and low, so that each event is shown to follow its own condition.

// File: rtl/irq_regwin_pkg.sv
package irq_regwin_pkg;

   // bit positions inside a 64-bit redirection entry
   localparam int F_DLVS = 12;
   localparam int F_RIRR = 14;
   localparam int F_TRIG = 15;
   localparam int F_MASK = 16;

   // software-writable bits of the low half
   localparam logic [31:0] LO_WMASK  = ~((32'h1 << F_DLVS) | (32'h1 << F_RIRR));
   localparam logic [31:0] LO_RESET  = 32'h1 << F_MASK;

   // select codes of the fixed words
   localparam logic [7:0] SEL_ID   = 8'h00;
   localparam logic [7:0] SEL_VER  = 8'h01;
   localparam logic [7:0] SEL_ARB  = 8'h02;
   localparam logic [7:0] SEL_TBL0 = 8'h10;

   typedef enum logic [2:0] {
      TGT_ID,
      TGT_VER,
      TGT_ARB,
      TGT_TBL,
      TGT_VOID
   } win_tgt_e;

endpackage

// File: rtl/irq_regwin_decode.sv
module irq_regwin_decode
   import irq_regwin_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int PINS    = 24,
   parameter int SEL_OFS = 0,
   parameter int WIN_OFS = 16,
   localparam int IDX_W  = (PINS > 1) ? $clog2(PINS) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        sel,
   output logic              hit_sel,
   output logic              hit_win,
   output win_tgt_e          tgt,
   output logic [IDX_W-1:0]  idx,
   output logic              hi
);

   localparam logic [ADDR_W-1:0] SEL_A = ADDR_W'(SEL_OFS);
   localparam logic [ADDR_W-1:0] WIN_A = ADDR_W'(WIN_OFS);
   localparam logic [7:0]        PINS8 = 8'(PINS);

   logic       aligned;
   logic [7:0] raw;

   always_comb begin
      aligned = (addr[3:0] == 4'h0);
      hit_sel = aligned && (addr == SEL_A);
      hit_win = aligned && (addr == WIN_A);
   end

   always_comb begin
      raw = (sel - SEL_TBL0) >> 1;
      idx = IDX_W'(raw);
      hi  = sel[0];
      if (sel == SEL_ID)
         tgt = TGT_ID;
      else if (sel == SEL_VER)
         tgt = TGT_VER;
      else if (sel == SEL_ARB)
         tgt = TGT_ARB;
      else if ((sel >= SEL_TBL0) && (raw < PINS8))
         tgt = TGT_TBL;
      else
         tgt = TGT_VOID;
   end

endmodule

// File: rtl/irq_regwin_entry.sv
module irq_regwin_entry
   import irq_regwin_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_lo,
   input  logic        wr_hi,
   input  logic [31:0] wdata,
   input  logic        hw_set,
   input  logic        hw_clr,
   input  logic        hw_dlv,
   output logic [63:0] ent_q
);

   logic [31:0] lo_q, hi_q;
   logic [31:0] lo_cfg, lo_n, hi_n;
   logic        rirr_n;

   always_comb begin
      lo_cfg = wr_lo ? ((wdata & LO_WMASK) | (lo_q & ~LO_WMASK)) : lo_q;
      hi_n   = wr_hi ? wdata : hi_q;
      if (hw_set)
         rirr_n = 1'b1;
      else if (hw_clr)
         rirr_n = 1'b0;
      else
         rirr_n = lo_q[F_RIRR];
      if ((wr_lo || wr_hi) && !lo_cfg[F_TRIG])
         rirr_n = 1'b0;
      lo_n          = lo_cfg;
      lo_n[F_RIRR]  = rirr_n;
      lo_n[F_DLVS]  = hw_dlv;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q <= LO_RESET;
         hi_q <= '0;
      end else begin
         lo_q <= lo_n;
         hi_q <= hi_n;
      end
   end

   assign ent_q = {hi_q, lo_q};

   // R9: an entry left edge-triggered by a write has remote-IRR clear
   p_edge_clears_rirr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo || wr_hi) |=> (ent_q[F_TRIG] || !ent_q[F_RIRR]));

   // R8: a level-mode low write keeps remote-IRR
   p_keep_rirr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && wdata[F_TRIG] && !hw_set && !hw_clr)
      |=> (ent_q[F_RIRR] == $past(ent_q[F_RIRR])));

   // R13: servicing logic sets remote-IRR
   p_hw_set_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_set && !wr_lo && !wr_hi) |=> ent_q[F_RIRR]);

endmodule

// File: rtl/irq_regwin.sv
module irq_regwin
   import irq_regwin_pkg::*;
#(
   parameter int          ADDR_W  = 8,
   parameter int          PINS    = 24,
   parameter logic [7:0]  VERSION = 8'h20,
   parameter int          SEL_OFS = 0,
   parameter int          WIN_OFS = 16,
   localparam int         IDX_W   = (PINS > 1) ? $clog2(PINS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic                  req_write,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [31:0]           req_wdata,
   output logic                  rsp_valid,
   output logic [31:0]           rsp_rdata,
   input  logic [PINS-1:0]       pin_pend,
   input  logic [PINS-1:0]       hw_rirr_set,
   input  logic [PINS-1:0]       hw_rirr_clr,
   input  logic [PINS-1:0]       hw_dlv_stat,
   output logic [PINS-1:0][63:0] tbl_q,
   output logic                  mask_chg_vld,
   output logic [IDX_W-1:0]      mask_chg_pin,
   output logic                  mask_chg_val,
   output logic                  reeval_vld,
   output logic [IDX_W-1:0]      reeval_pin
);

   localparam logic [7:0] MAXPIN = 8'(PINS - 1);

   // elaboration-time parameter checks
   generate
      if (PINS < 1 || PINS > 120) begin : g_bad_pins
         $error("irq_regwin: PINS must lie in 1..120");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("irq_regwin: ADDR_W must be at least 5");
      end
      if ((SEL_OFS % 16) != 0 || (WIN_OFS % 16) != 0 || SEL_OFS == WIN_OFS) begin : g_bad_ofs
         $error("irq_regwin: offsets must be distinct and 16-byte aligned");
      end
   endgenerate

   logic             rdy_q;
   logic [7:0]       sel_q;
   logic [3:0]       id_q;
   logic             hit_sel, hit_win, tbl_hi;
   win_tgt_e         tgt;
   logic [IDX_W-1:0] tbl_idx;
   logic             acc, acc_wr, acc_rd, tbl_wr;
   logic             old_mask, new_trig;
   logic [31:0]      rd_n;
   logic [PINS-1:0]  wr_lo_v, wr_hi_v;

   irq_regwin_decode #(
      .ADDR_W (ADDR_W),
      .PINS   (PINS),
      .SEL_OFS(SEL_OFS),
      .WIN_OFS(WIN_OFS)
   ) u_dec (
      .addr   (req_addr),
      .sel    (sel_q),
      .hit_sel(hit_sel),
      .hit_win(hit_win),
      .tgt    (tgt),
      .idx    (tbl_idx),
      .hi     (tbl_hi)
   );

   assign req_ready = rdy_q;

   always_comb begin
      acc    = req_valid && rdy_q;
      acc_wr = acc && req_write;
      acc_rd = acc && !req_write;
      tbl_wr = acc_wr && hit_win && (tgt == TGT_TBL);
   end

   // per-pin entry storage
   generate
      for (genvar p = 0; p < PINS; p++) begin : g_pin
         always_comb begin
            wr_lo_v[p] = tbl_wr && (tbl_idx == IDX_W'(p)) && !tbl_hi;
            wr_hi_v[p] = tbl_wr && (tbl_idx == IDX_W'(p)) && tbl_hi;
         end
         irq_regwin_entry u_ent (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_lo (wr_lo_v[p]),
            .wr_hi (wr_hi_v[p]),
            .wdata (req_wdata),
            .hw_set(hw_rirr_set[p]),
            .hw_clr(hw_rirr_clr[p]),
            .hw_dlv(hw_dlv_stat[p]),
            .ent_q (tbl_q[p])
         );
      end
   endgenerate

   // select, identification, handshake
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdy_q <= 1'b0;
         sel_q <= '0;
         id_q  <= '0;
      end else begin
         rdy_q <= 1'b1;
         if (acc_wr && hit_sel)
            sel_q <= req_wdata[7:0];
         if (acc_wr && hit_win && (tgt == TGT_ID))
            id_q <= req_wdata[27:24];
      end
   end

   // read mux
   always_comb begin
      rd_n = '0;
      if (hit_sel) begin
         rd_n = {24'h0, sel_q};
      end else if (hit_win) begin
         case (tgt)
            TGT_ID, TGT_ARB: rd_n = {4'h0, id_q, 24'h0};
            TGT_VER:         rd_n = {8'h00, MAXPIN, 8'h00, VERSION};
            TGT_TBL:         rd_n = tbl_hi ? tbl_q[tbl_idx][63:32] : tbl_q[tbl_idx][31:0];
            default:         rd_n = '1;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= acc_rd;
         if (acc_rd)
            rsp_rdata <= rd_n;
      end
   end

   // event pulses
   always_comb begin
      old_mask = tbl_q[tbl_idx][F_MASK];
      new_trig = tbl_hi ? tbl_q[tbl_idx][F_TRIG] : req_wdata[F_TRIG];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_chg_vld <= 1'b0;
         mask_chg_pin <= '0;
         mask_chg_val <= 1'b0;
         reeval_vld   <= 1'b0;
         reeval_pin   <= '0;
      end else begin
         mask_chg_vld <= tbl_wr && !tbl_hi && (old_mask != req_wdata[F_MASK]);
         reeval_vld   <= tbl_wr && new_trig && pin_pend[tbl_idx];
         if (tbl_wr) begin
            mask_chg_pin <= tbl_idx;
            mask_chg_val <= req_wdata[F_MASK];
            reeval_pin   <= tbl_idx;
         end
      end
   end

   // R3: select keeps the low byte of the data
   p_sel_low8_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && hit_sel) |=> (sel_q == $past(req_wdata[7:0])));

   // R10: a response follows every accepted read and nothing else
   p_rsp_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !req_write) |=> rsp_valid);
   p_rsp_only_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid && req_ready && !req_write));

   // R11: a mask event only follows a write
   p_mask_evt_after_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mask_chg_vld |-> $past(req_valid && req_ready && req_write));

   // R7: writes to void selects raise no event
   p_void_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && hit_win && (tgt == TGT_VOID)) |=> (!mask_chg_vld && !reeval_vld));

endmodule

// File: tb/tb_irq_regwin.sv
module tb_irq_regwin;

   localparam int PINS  = 24;
   localparam int IDX_W = 5;
   localparam logic [7:0] SEL_A = 8'h00;
   localparam logic [7:0] WIN_A = 8'h10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [7:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic req_ready, rsp_valid;
   logic [31:0] rsp_rdata;
   logic [PINS-1:0] pin_pend = '0, hw_rirr_set = '0, hw_rirr_clr = '0, hw_dlv_stat = '0;
   logic [PINS-1:0][63:0] tbl;
   logic mask_chg_vld, mask_chg_val, reeval_vld;
   logic [IDX_W-1:0] mask_chg_pin, reeval_pin;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #2.5 clk = ~clk;

   irq_regwin dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .pin_pend(pin_pend), .hw_rirr_set(hw_rirr_set), .hw_rirr_clr(hw_rirr_clr),
      .hw_dlv_stat(hw_dlv_stat), .tbl_q(tbl),
      .mask_chg_vld(mask_chg_vld), .mask_chg_pin(mask_chg_pin), .mask_chg_val(mask_chg_val),
      .reeval_vld(reeval_vld), .reeval_pin(reeval_pin)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: pops expected read data as responses appear
   always @(negedge clk) begin
      if (rst_n && !done && rsp_valid) begin
         if (exp_q.size() == 0) begin
            n_vec++;
            n_bad++;
            $display("FAIL R10: unexpected response %h expected none", rsp_rdata);
         end else begin
            chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
         end
      end
   end

   // all tasks start and end at a falling edge
   task automatic tick(int n);
      repeat (n) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, logic [31:0] e, string tag);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic win_rd(logic [7:0] s, logic [31:0] e, string tag);
      wr(SEL_A, {24'h0, s});
      rd(WIN_A, e, tag);
   endtask

   task automatic win_wr(logic [7:0] s, logic [31:0] d);
      wr(SEL_A, {24'h0, s});
      wr(WIN_A, d);
   endtask

   task automatic evt(string tag, logic mv, logic [4:0] mp, logic mval, logic rv, logic [4:0] rp);
      chk({tag, " mask_vld"}, {31'h0, mask_chg_vld}, {31'h0, mv});
      if (mv) chk({tag, " mask_pin/val"}, {26'h0, mask_chg_pin, mask_chg_val}, {26'h0, mp, mval});
      chk({tag, " reeval_vld"}, {31'h0, reeval_vld}, {31'h0, rv});
      if (rv) chk({tag, " reeval_pin"}, {27'h0, reeval_pin}, {27'h0, rp});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R1 reset state, R10 ready
      chk("R10 ready", {31'h0, req_ready}, 32'h1);
      rd(SEL_A, 32'h0, "R1 select");
      rd(WIN_A, 32'h0, "R1 id");
      for (int p = 0; p < PINS; p++) begin
         win_rd(8'(8'h10 + 2 * p), 32'h0001_0000, "R1 entry lo");
         win_rd(8'(8'h11 + 2 * p), 32'h0, "R1 entry hi");
      end

      // R3 select low byte
      wr(SEL_A, 32'hABCD_1234);
      rd(SEL_A, 32'h0000_0034, "R3 select");

      // R4 version
      win_rd(8'h01, 32'h0017_0020, "R4 version");
      wr(WIN_A, 32'hFFFF_FFFF);
      rd(WIN_A, 32'h0017_0020, "R4 version after write");

      // R5 identification and arbitration
      win_wr(8'h00, 32'hFFFF_FFFF);
      rd(WIN_A, 32'h0F00_0000, "R5 id");
      win_rd(8'h02, 32'h0F00_0000, "R5 arb");
      wr(WIN_A, 32'h0);
      win_rd(8'h00, 32'h0F00_0000, "R5 arb write ignored");
      wr(WIN_A, 32'h5A00_0000);
      rd(WIN_A, 32'h0A00_0000, "R5 id nibble");

      // R2 dead offsets and unaligned access
      wr(SEL_A, 32'h0000_0002);
      rd(8'h20, 32'h0, "R2 offset 0x20");
      rd(8'h30, 32'h0, "R2 offset 0x30");
      rd(8'h04, 32'h0, "R2 unaligned");
      rd(8'h14, 32'h0, "R2 unaligned near window");
      wr(8'h20, 32'h0000_0055);
      wr(8'h01, 32'h0000_0077);
      rd(SEL_A, 32'h0000_0002, "R2 writes ignored");

      // R6 / R11 table round trip on pin 5
      win_wr(8'h1A, 32'h0000_8B31);
      evt("R11 unmask pin5", 1'b1, 5'd5, 1'b0, 1'b0, 5'd0);
      rd(WIN_A, 32'h0000_8B31, "R6 lo");
      win_wr(8'h1B, 32'hC300_0000);
      evt("R11 hi write", 1'b0, 5'd0, 1'b0, 1'b0, 5'd0);
      rd(WIN_A, 32'hC300_0000, "R6 hi");
      chk("R6 exported dest", {24'h0, tbl[5][63:56]}, 32'h0000_00C3);

      // R8 protected bits in data ignored
      win_wr(8'h1A, 32'h0000_DB31);
      evt("R11 same mask", 1'b0, 5'd0, 1'b0, 1'b0, 5'd0);
      rd(WIN_A, 32'h0000_8B31, "R8 status bits not written");

      // R13 / R8 servicing inputs
      hw_rirr_set[5] = 1'b1; tick(1); hw_rirr_set[5] = 1'b0;
      rd(WIN_A, 32'h0000_CB31, "R13 rirr set");
      wr(WIN_A, 32'h0000_8B31);
      rd(WIN_A, 32'h0000_CB31, "R8 rirr kept");
      hw_dlv_stat[5] = 1'b1; tick(1);
      wr(WIN_A, 32'h0000_8B31);
      rd(WIN_A, 32'h0000_DB31, "R8 delivery status kept");
      hw_rirr_clr[5] = 1'b1; tick(1); hw_rirr_clr[5] = 1'b0;
      rd(WIN_A, 32'h0000_9B31, "R13 rirr clear");
      hw_rirr_set[5] = 1'b1; tick(1); hw_rirr_set[5] = 1'b0;
      // R9 edge write clears remote-IRR
      wr(WIN_A, 32'h0000_0B31);
      rd(WIN_A, 32'h0000_1B31, "R9 edge clears rirr");
      hw_dlv_stat[5] = 1'b0; tick(1);
      rd(WIN_A, 32'h0000_0B31, "R13 delivery status follows");

      // R12 re-evaluation on pin 7
      pin_pend[7] = 1'b1;
      win_wr(8'h1E, 32'h0001_8040);
      evt("R12 level pending", 1'b0, 5'd0, 1'b0, 1'b1, 5'd7);
      wr(WIN_A, 32'h0001_0040);
      evt("R12 edge no event", 1'b0, 5'd0, 1'b0, 1'b0, 5'd0);
      wr(WIN_A, 32'h0001_8040);
      evt("R12 level again", 1'b0, 5'd0, 1'b0, 1'b1, 5'd7);
      win_wr(8'h1F, 32'hFF00_0000);
      evt("R12 hi write", 1'b0, 5'd0, 1'b0, 1'b1, 5'd7);
      pin_pend[7] = 1'b0;
      wr(WIN_A, 32'hEE00_0000);
      evt("R12 not pending", 1'b0, 5'd0, 1'b0, 1'b0, 5'd0);
      win_wr(8'h1E, 32'h0000_8040);
      evt("R11 unmask pin7", 1'b1, 5'd7, 1'b0, 1'b0, 5'd0);

      // R7 void selects
      win_rd(8'h40, 32'hFFFF_FFFF, "R7 index PINS lo");
      win_rd(8'h41, 32'hFFFF_FFFF, "R7 index PINS hi");
      win_rd(8'h05, 32'hFFFF_FFFF, "R7 gap select");
      win_rd(8'hFF, 32'hFFFF_FFFF, "R7 top select");
      win_wr(8'h40, 32'h0000_8000);
      evt("R7 write dropped", 1'b0, 5'd0, 1'b0, 1'b0, 5'd0);
      win_rd(8'h10, 32'h0001_0000, "R7 pin0 untouched");
      win_rd(8'h3E, 32'h0001_0000, "R7 last pin untouched");

      tick(2);
      chk("R10 all responses seen", exp_q.size(), 0);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule